// File: doc/BRIEF.md
# Isochronous OUT Ping-Pong Receive Buffer

This block is the receive store behind a USB device isochronous OUT endpoint. The packet engine on the bus side announces each OUT transaction with a start strobe. It then streams data bytes, and closes the transaction with an end-of-packet strobe or a bad-packet strobe. The block holds at most two packets in two equal halves of its storage. The two halves are filled in turn. The block answers each new transaction with a one-cycle accept or NAK pulse.

On the system side, one 8-bit read port drains packets in arrival order. Either a DMA engine or the processor can use it. A level interrupt shows that a complete packet is waiting, and a DMA request line follows the same state when DMA is enabled. A remaining-byte count tells the reader where the current packet ends. A half that has been partly read still counts as occupied. A new transaction is accepted only once a whole half is free again.

Top module: `iso_out_pingpong`

## Requirements
- R1: After reset, `irq`, `dma_req`, `hs_ack`, `hs_nak` and `overrun` are 0, and `rd_data` and `rd_level` read 0.
- R2: A `rx_start` that finds the next write half empty is accepted. Data bytes (`rx_valid`) are stored in order. The cycle after `rx_eop`, the packet is ready and `rd_level` shows its byte count while it is at the head.
- R3: In the cycle after every `rx_start`, exactly one of `hs_ack` and `hs_nak` is high for one cycle. Neither pulses at any other time.
- R4: `rd_data[7:0]` shows the next unread byte of the oldest ready packet. Each cycle with `rd_en` high consumes one byte and decrements `rd_level`. Packets come out in the order they were received.
- R5: A `rx_start` is answered with `hs_nak` while the next write half is not empty, including when it is being drained. Bytes of a NAKed transaction are not stored. NAKs continue until that half has been read to its last byte.
- R6: `irq` is high while at least one complete packet is waiting, and low once both halves are empty.
- R7: `rd_data[31:8]` always reads 0.
- R8: `dma_req` is high when `dma_en` is 1 and a packet is ready. It is low in the cycle after the last byte of a packet is consumed. It rises again one cycle later if another packet is ready. With `dma_en` 0 it stays low.
- R9: `rx_bad` before `rx_eop` discards the open packet. No interrupt or DMA request follows, and the same half accepts the next transaction.
- R10: A packet of 128 bytes is kept. A 129th byte discards the packet and sets `overrun`, which stays set until reset.
- R11: `rd_en` while nothing is ready returns 0 on `rd_data` and moves no pointer. A packet received afterwards reads out from its first byte.
- R12: An `rx_eop` with no data bytes is discarded and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Enables the DMA request line |
| rx_start | input | 1 | Strobe: a new OUT transaction has begun |
| rx_valid | input | 1 | Strobe: `rx_byte` carries a data byte |
| rx_byte | input | 8 | Received data byte |
| rx_eop | input | 1 | Strobe: the open packet ended well (carries no data) |
| rx_bad | input | 1 | Strobe: the open packet is corrupt |
| rd_en | input | 1 | Consume the head byte |
| rd_data | output | 32 | Head byte in bits 7:0, upper bits zero |
| rd_level | output | 8 | Unread bytes left in the head packet |
| irq | output | 1 | A complete packet is waiting |
| dma_req | output | 1 | DMA service request |
| hs_ack | output | 1 | Pulse: transaction accepted |
| hs_nak | output | 1 | Pulse: transaction refused |
| overrun | output | 1 | Sticky: an oversize packet was dropped |

## Verification
Directed sequences fill both halves and then probe with a new transaction at three points: with both halves full, with the head half partly drained, and after it is fully drained. This separates a NAK tied to whole-half release from one tied to free bytes. Bad, empty, exactly-128-byte and 130-byte packets show which packets reach the read side, and in which half the next one lands. Idle reads check that pointers stay put. A seeded random mix of packet lengths, partial reads, bad strobes and DMA enable settings is compared against a queue model, byte by byte and on every handshake.

// File: rtl/iso_out_pkg.sv
package iso_out_pkg;

    localparam int NUM_SLOTS = 2;

    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_FILLING = 2'd1,
        SLOT_READY   = 2'd2
    } slot_state_e;

    // One-hot select of a half from its index bit.
    function automatic logic [NUM_SLOTS-1:0] slot_onehot(input logic sel);
        return sel ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/iso_out_store.sv
module iso_out_store #(
    parameter int SLOT_BYTES = 128,
    parameter int DATA_W     = 8,
    parameter int PTR_W      = 7
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_slot,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              rd_slot,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_byte
);
    localparam int DEPTH = iso_out_pkg::NUM_SLOTS * SLOT_BYTES;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[{wr_slot, wr_ptr}] <= wr_byte;
    end

    assign rd_byte = mem[{rd_slot, rd_ptr}];
endmodule

// File: rtl/iso_out_slots.sv
module iso_out_slots #(
    parameter int CNT_W = 8
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [iso_out_pkg::NUM_SLOTS-1:0]       claim,
    input  logic [iso_out_pkg::NUM_SLOTS-1:0]       drop,
    input  logic [iso_out_pkg::NUM_SLOTS-1:0]       commit,
    input  logic [iso_out_pkg::NUM_SLOTS-1:0]       release_slot,
    input  logic [CNT_W-1:0]                        commit_cnt,
    output logic [iso_out_pkg::NUM_SLOTS-1:0]       empty,
    output logic [iso_out_pkg::NUM_SLOTS-1:0]       ready,
    output logic [iso_out_pkg::NUM_SLOTS-1:0][CNT_W-1:0] count
);
    import iso_out_pkg::*;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        slot_state_e      st;
        logic [CNT_W-1:0] len;

        always_ff @(posedge clk) begin
            if (rst) begin
                st  <= SLOT_EMPTY;
                len <= '0;
            end else begin
                unique case (st)
                    SLOT_EMPTY:   if (claim[g]) st <= SLOT_FILLING;
                    SLOT_FILLING: begin
                        if (drop[g]) begin
                            st <= SLOT_EMPTY;
                        end else if (commit[g]) begin
                            st  <= SLOT_READY;
                            len <= commit_cnt;
                        end
                    end
                    SLOT_READY:   if (release_slot[g]) st <= SLOT_EMPTY;
                    default:      st <= SLOT_EMPTY;
                endcase
            end
        end

        assign empty[g] = (st == SLOT_EMPTY);
        assign ready[g] = (st == SLOT_READY);
        assign count[g] = len;
    end
endmodule

// File: rtl/iso_out_fill.sv
module iso_out_fill #(
    parameter int SLOT_BYTES = 128,
    parameter int CNT_W      = 8,
    parameter int PTR_W      = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_start,
    input  logic             rx_valid,
    input  logic             rx_eop,
    input  logic             rx_bad,
    input  logic             wslot_empty,
    output logic             wsel,
    output logic             claim,
    output logic             drop,
    output logic             commit,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [CNT_W-1:0] commit_cnt,
    output logic             ack,
    output logic             nak,
    output logic             overrun
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOT_BYTES);

    logic             active;
    logic [CNT_W-1:0] wcnt;
    logic             too_long;
    logic             take;

    // Event decode; a start strobe outranks the data-phase strobes.
    always_comb begin
        claim    = 1'b0;
        drop     = 1'b0;
        commit   = 1'b0;
        wr_en    = 1'b0;
        too_long = 1'b0;
        take     = rx_start && !active && wslot_empty;
        if (rx_start) begin
            if (active)           drop  = 1'b1;   // open packet abandoned
            else if (wslot_empty) claim = 1'b1;
        end else if (active) begin
            if (rx_bad) begin
                drop = 1'b1;
            end else if (rx_eop) begin
                if (wcnt == '0) drop   = 1'b1;
                else            commit = 1'b1;
            end else if (rx_valid) begin
                if (wcnt == FULL) begin
                    drop     = 1'b1;
                    too_long = 1'b1;
                end else begin
                    wr_en = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            wcnt    <= '0;
            wsel    <= 1'b0;
            ack     <= 1'b0;
            nak     <= 1'b0;
            overrun <= 1'b0;
        end else begin
            ack <= take;
            nak <= rx_start && !take;
            if (claim) begin
                active <= 1'b1;
                wcnt   <= '0;
            end
            if (drop || commit) active <= 1'b0;
            if (commit)         wsel   <= ~wsel;
            if (wr_en)          wcnt   <= wcnt + CNT_W'(1);
            if (too_long)       overrun <= 1'b1;
        end
    end

    assign wr_ptr     = wcnt[PTR_W-1:0];
    assign commit_cnt = wcnt;
endmodule

// File: rtl/iso_out_drain.sv
module iso_out_drain #(
    parameter int CNT_W = 8,
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic             head_ready,
    input  logic [CNT_W-1:0] head_cnt,
    output logic             rsel,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             release_o,
    output logic             gap,
    output logic [CNT_W-1:0] level
);
    logic [CNT_W-1:0] rcnt;
    logic             fire;

    assign fire      = rd_en && head_ready;
    assign release_o = fire && ((rcnt + CNT_W'(1)) == head_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            rcnt <= '0;
            rsel <= 1'b0;
            gap  <= 1'b0;
        end else begin
            gap <= release_o;
            if (release_o) begin
                rcnt <= '0;
                rsel <= ~rsel;
            end else if (fire) begin
                rcnt <= rcnt + CNT_W'(1);
            end
        end
    end

    assign rd_ptr = rcnt[PTR_W-1:0];
    assign level  = head_ready ? (head_cnt - rcnt) : '0;
endmodule

// File: rtl/iso_out_pingpong.sv
module iso_out_pingpong #(
    parameter int SLOT_BYTES = 128,
    parameter int DATA_W     = 8,
    parameter int BUS_W      = 32,
    parameter int CNT_W      = $clog2(SLOT_BYTES + 1),
    parameter int PTR_W      = $clog2(SLOT_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_en,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_eop,
    input  logic              rx_bad,
    input  logic              rd_en,
    output logic [BUS_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  rd_level,
    output logic              irq,
    output logic              dma_req,
    output logic              hs_ack,
    output logic              hs_nak,
    output logic              overrun
);
    import iso_out_pkg::*;

    logic                            wsel, rsel;
    logic                            claim, drop, commit, wr_en;
    logic [PTR_W-1:0]                wr_ptr, rd_ptr;
    logic [CNT_W-1:0]                commit_cnt;
    logic [NUM_SLOTS-1:0]            slot_empty, slot_ready;
    logic [NUM_SLOTS-1:0][CNT_W-1:0] slot_cnt;
    logic                            release_o, gap;
    logic                            head_ready;
    logic [DATA_W-1:0]               head_byte;
    logic [NUM_SLOTS-1:0]            wsel_oh, rsel_oh;

    assign wsel_oh    = slot_onehot(wsel);
    assign rsel_oh    = slot_onehot(rsel);
    assign head_ready = slot_ready[rsel];

    iso_out_fill #(
        .SLOT_BYTES(SLOT_BYTES), .CNT_W(CNT_W), .PTR_W(PTR_W)
    ) u_fill (
        .clk(clk), .rst(rst),
        .rx_start(rx_start), .rx_valid(rx_valid),
        .rx_eop(rx_eop), .rx_bad(rx_bad),
        .wslot_empty(slot_empty[wsel]),
        .wsel(wsel), .claim(claim), .drop(drop), .commit(commit),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .commit_cnt(commit_cnt),
        .ack(hs_ack), .nak(hs_nak), .overrun(overrun)
    );

    iso_out_slots #(.CNT_W(CNT_W)) u_slots (
        .clk(clk), .rst(rst),
        .claim(claim ? wsel_oh : '0),
        .drop(drop ? wsel_oh : '0),
        .commit(commit ? wsel_oh : '0),
        .release_slot(release_o ? rsel_oh : '0),
        .commit_cnt(commit_cnt),
        .empty(slot_empty), .ready(slot_ready), .count(slot_cnt)
    );

    iso_out_drain #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_drain (
        .clk(clk), .rst(rst),
        .rd_en(rd_en), .head_ready(head_ready), .head_cnt(slot_cnt[rsel]),
        .rsel(rsel), .rd_ptr(rd_ptr), .release_o(release_o),
        .gap(gap), .level(rd_level)
    );

    iso_out_store #(
        .SLOT_BYTES(SLOT_BYTES), .DATA_W(DATA_W), .PTR_W(PTR_W)
    ) u_store (
        .clk(clk),
        .wr_en(wr_en), .wr_slot(wsel), .wr_ptr(wr_ptr), .wr_byte(rx_byte),
        .rd_slot(rsel), .rd_ptr(rd_ptr), .rd_byte(head_byte)
    );

    assign rd_data = head_ready ? {{(BUS_W-DATA_W){1'b0}}, head_byte} : '0;
    assign irq     = |slot_ready;
    assign dma_req = dma_en && head_ready && !gap;
endmodule

// File: rtl/iso_out_pingpong_chk.sv
module iso_out_pingpong_chk #(
    parameter int DATA_W = 8,
    parameter int BUS_W  = 32,
    parameter int CNT_W  = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             dma_en,
    input logic             rx_start,
    input logic             rd_en,
    input logic [BUS_W-1:0] rd_data,
    input logic [CNT_W-1:0] rd_level,
    input logic             irq,
    input logic             dma_req,
    input logic             hs_ack,
    input logic             hs_nak,
    input logic             overrun,
    input logic [1:0]       slot_empty
);
    a_r3_one_handshake: assert property (@(posedge clk) disable iff (rst)
        rx_start |=> (hs_ack ^ hs_nak));

    a_r3_no_stray_handshake: assert property (@(posedge clk) disable iff (rst)
        !rx_start |=> (!hs_ack && !hs_nak));

    a_r5_nak_when_occupied: assert property (@(posedge clk) disable iff (rst)
        (rx_start && slot_empty == 2'b00) |=> hs_nak);

    a_r6_irq_low_when_empty: assert property (@(posedge clk) disable iff (rst)
        (slot_empty == 2'b11) |-> !irq);

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[BUS_W-1:DATA_W] == '0);

    a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (rd_data == '0 && rd_level == '0));

    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    a_r8_dma_gap: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_level == CNT_W'(1)) |=> !dma_req);

    a_r8_dma_gated: assert property (@(posedge clk) disable iff (rst)
        !dma_en |-> !dma_req);
endmodule

bind iso_out_pingpong iso_out_pingpong_chk #(
    .DATA_W(DATA_W), .BUS_W(BUS_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .dma_en(dma_en), .rx_start(rx_start), .rd_en(rd_en),
    .rd_data(rd_data), .rd_level(rd_level), .irq(irq), .dma_req(dma_req),
    .hs_ack(hs_ack), .hs_nak(hs_nak), .overrun(overrun),
    .slot_empty(slot_empty)
);

// File: tb/iso_out_pingpong_bench.sv
`timescale 1ns/1ps
module iso_out_pingpong_bench;
    localparam int SLOT = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dma_en = 1'b0, rx_start = 1'b0, rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_eop = 1'b0, rx_bad = 1'b0, rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [7:0]  rd_level;
    logic        irq, dma_req, hs_ack, hs_nak, overrun;

    always #4 clk = ~clk;

    iso_out_pingpong u_iso_out_pingpong (
        .clk(clk), .rst(rst), .dma_en(dma_en), .rx_start(rx_start),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eop(rx_eop),
        .rx_bad(rx_bad), .rd_en(rd_en), .rd_data(rd_data),
        .rd_level(rd_level), .irq(irq), .dma_req(dma_req),
        .hs_ack(hs_ack), .hs_nak(hs_nak), .overrun(overrun)
    );

    int n_chk = 0, n_bad = 0, pkt_id = 0;
    bit exp_ovr = 1'b0, finished = 1'b0;
    logic [7:0] mq[$];   // bytes of ready packets, oldest first
    int         lq[$];   // unread bytes per ready packet

    function automatic logic [7:0] make_byte(int id, int i);
        return 8'(((id * 53) + (i * 7) + (i >> 3)) ^ 32'h5A);
    endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // One OUT transaction: start, len data bytes, then eop or bad.
    task automatic send(int len, bit bad);
        bit accept = (lq.size() < 2);
        pkt_id++;
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        check_eq(accept ? "R3/R2" : "R5", "hs_ack", int'(hs_ack), int'(accept));
        check_eq(accept ? "R3/R2" : "R5", "hs_nak", int'(hs_nak), int'(!accept));
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_byte  = make_byte(pkt_id, i);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        if (bad) rx_bad = 1'b1; else rx_eop = 1'b1;
        @(negedge clk);
        rx_bad = 1'b0;
        rx_eop = 1'b0;
        if (accept && len > SLOT) exp_ovr = 1'b1;
        if (accept && !bad && len > 0 && len <= SLOT) begin
            for (int i = 0; i < len; i++) mq.push_back(make_byte(pkt_id, i));
            lq.push_back(len);
        end
        check_eq("R6/R9/R12", "irq", int'(irq), int'(lq.size() > 0));
        check_eq("R10", "overrun", int'(overrun), int'(exp_ovr));
    endtask

    // Consume n bytes of the head packet (n not above its remainder).
    task automatic read_bytes(int n);
        check_eq("R8", "dma_req", int'(dma_req), int'(dma_en));
        for (int i = 0; i < n; i++) begin
            check_eq("R4", "rd_data", int'(rd_data[7:0]), int'(mq[0]));
            check_eq("R7", "rd_data upper", int'(rd_data[31:8]), 0);
            check_eq("R2/R4", "rd_level", int'(rd_level), lq[0]);
            rd_en = 1'b1;
            @(negedge clk);
            void'(mq.pop_front());
            lq[0] = lq[0] - 1;
            if (lq[0] == 0) begin
                void'(lq.pop_front());
                rd_en = 1'b0;
                check_eq("R8", "dma_req gap", int'(dma_req), 0);
                @(negedge clk);
                check_eq("R8", "dma_req after gap", int'(dma_req),
                         int'(dma_en && lq.size() > 0));
                check_eq("R6", "irq", int'(irq), int'(lq.size() > 0));
            end
        end
        rd_en = 1'b0;
    endtask

    task automatic idle_read();
        check_eq("R11", "rd_data idle", int'(rd_data), 0);
        check_eq("R11", "rd_level idle", int'(rd_level), 0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check_eq("R11", "rd_data after idle read", int'(rd_data), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1", "irq", int'(irq), 0);
        check_eq("R1", "dma_req", int'(dma_req), 0);
        check_eq("R1", "hs_ack", int'(hs_ack), 0);
        check_eq("R1", "hs_nak", int'(hs_nak), 0);
        check_eq("R1", "overrun", int'(overrun), 0);
        check_eq("R1", "rd_data", int'(rd_data), 0);
        check_eq("R1", "rd_level", int'(rd_level), 0);

        // R11 idle read then a packet reads from its first byte
        dma_en = 1'b1;
        idle_read();
        idle_read();
        send(5, 1'b0);
        read_bytes(5);

        // R5 both halves full, then partly drained head, then released
        send(SLOT, 1'b0);          // R10 boundary: exactly full is kept
        send(10, 1'b0);
        send(3, 1'b0);             // NAK, bytes ignored
        read_bytes(4);
        send(6, 1'b0);             // still NAK: head only partly drained
        read_bytes(SLOT - 4);
        send(7, 1'b0);             // accepted into freed half
        read_bytes(10);
        read_bytes(7);

        // R9 bad packet dropped, half reused
        send(6, 1'b1);
        check_eq("R9", "dma_req after bad", int'(dma_req), 0);
        send(4, 1'b0);
        read_bytes(4);

        // R12 zero-length
        send(0, 1'b0);
        check_eq("R12", "rd_level", int'(rd_level), 0);

        // R10 oversize packet
        send(SLOT + 2, 1'b0);
        send(9, 1'b0);
        read_bytes(9);

        // R8 DMA disabled
        dma_en = 1'b0;
        send(3, 1'b0);
        check_eq("R8", "dma_req disabled", int'(dma_req), 0);
        read_bytes(3);
        idle_read();

        // Random mix
        for (int k = 0; k < 70; k++) begin
            int op = int'($urandom % 4);
            if ($urandom % 6 == 0) dma_en = ~dma_en;
            if (op < 2) begin
                send(1 + int'($urandom % SLOT), ($urandom % 8) == 0);
            end else if (lq.size() > 0) begin
                int n = (op == 2) ? lq[0] : 1 + int'($urandom % lq[0]);
                read_bytes(n);
            end else begin
                idle_read();
            end
        end
        while (lq.size() > 0) read_bytes(lq[0]);
        idle_read();
        report();
    end
endmodule